// File: doc/BRIEF.md
# Byte-Bus 16-bit Timer with Capture and Compare

This block is a 16-bit free-running counter with two compare channels and one capture register, all reached from an 8-bit processor register bus. Each 16-bit register spans two byte addresses. A single 8-bit staging register, shared by every 16-bit register, makes each two-byte transfer atomic. Software writes the upper byte first, and that byte only waits in the staging register. The lower-byte write then moves both bytes into the target in one cycle. On the read side, fetching the lower byte also freezes the upper byte into the staging register, so a later upper-byte read returns a byte from the same sample.

The capture register takes the counter value on a rising edge of a selected source: either the external capture pin or the analog comparator output. That source is synchronized on chip first. The captured value can also serve as the counter's wrap point. Four event flags are kept: capture, compare A, compare B and overflow. Each flag drives its own interrupt request, gated by a mask bit and by a global enable.

Top module: `bytebus_timer16`

## Requirements
- R1: After reset the counter, both compare registers, the capture register, the mask, the flags and the control register are zero and all interrupt requests are low. Out of reset the counter advances by one on every clock.
- R2: A bus write to an upper-byte address loads only the shared staging register and leaves the addressed 16-bit register unchanged. The upper-byte addresses are 0x1 (counter), 0x3 (compare A), 0x5 (compare B) and 0x7 (capture).
- R3: A bus write to a lower-byte address commits {staging, write data} to the target in a single cycle. The lower-byte addresses are 0x0 (counter), 0x2 (compare A) and 0x4 (compare B). Because the staging register is shared, the upper byte comes from the most recent upper-byte write to any address.
- R4: A read of a lower-byte address (0x0, 0x2, 0x4, 0x6) returns that low byte in the same cycle and copies the matching upper byte into the staging register. A read of any upper-byte address returns the staging register.
- R5: A compare output (cmpa_match_o, cmpb_match_o) is high in exactly the cycles in which the counter equals that channel's compare value. The channel's flag sets on the following clock edge: flag bit 4 for compare A, bit 3 for compare B.
- R6: The capture source is the pin when cap_sel_i is 0 and the comparator when cap_sel_i is 1; the other input is ignored. The source passes two synchronizer flops and is detected on its rising edge. The capture register loads the counter value that is present two cycles after the source rises. Capture flag bit 5 sets in the same cycle.
- R7: When the counter wraps from 0xFFFF to 0x0000, overflow flag bit 2 sets on that same edge.
- R8: Bit 0 of the control register at address 0xA enables wrap-at-capture mode. While it is 1, a counter equal to the capture value goes to 0 on the next edge and sets overflow flag bit 2.
- R9: The mask register at address 0x8 uses bit 5 for capture, bit 4 for compare A, bit 3 for compare B and bit 2 for overflow. An interrupt request is high only while its flag, its mask bit and gie_i are all 1.
- R10: The flag register at address 0x9 clears a flag when 1 is written to its bit. Writing 0 has no effect, and a flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data, valid in the cycle of rd_i |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| acomp_i | input | 1 | Analog comparator output, asynchronous |
| cap_sel_i | input | 1 | Capture source select: 0 pin, 1 comparator |
| gie_i | input | 1 | Global interrupt enable |
| cmpa_match_o | output | 1 | Counter equals compare A |
| cmpb_match_o | output | 1 | Counter equals compare B |
| irq_cap_o | output | 1 | Capture interrupt request |
| irq_cmpa_o | output | 1 | Compare A interrupt request |
| irq_cmpb_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
All bus activity is driven on falling edges, and every timing below counts rising edges from that point.
- Read data is combinational, so the bench samples it one nanosecond after driving the strobe, within the same cycle.
- A lower-byte write takes effect on the next edge. The counter therefore holds the written value at the falling edge where the write task returns, and the bench predicts later counter and match values by adding the number of elapsed cycles.
- A capture is due three edges after the source rises: two synchronizer stages, then the load.
- A flag, and therefore its interrupt request, shows one edge after the counter condition that causes it.
- Each check sits at the exact falling edge where its result first appears, and where a lag matters, one cycle earlier as well.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 4;

    // Byte address map; bit 0 set marks an upper-byte address
    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO  = 4'h0,
        A_CNT_HI  = 4'h1,
        A_CMPA_LO = 4'h2,
        A_CMPA_HI = 4'h3,
        A_CMPB_LO = 4'h4,
        A_CMPB_HI = 4'h5,
        A_CAP_LO  = 4'h6,
        A_CAP_HI  = 4'h7,
        A_MASK    = 4'h8,
        A_FLAG    = 4'h9,
        A_CTRL    = 4'hA
    } tmr_addr_e;

    // Event sources; flag/mask bit position = FLAG_LSB + source index
    localparam int N_SRC    = 4;
    localparam int FLAG_LSB = 2;
    localparam int SRC_OVF  = 0;
    localparam int SRC_CMPB = 1;
    localparam int SRC_CMPA = 2;
    localparam int SRC_CAP  = 3;

    localparam int N_CMP    = 2;
    localparam int CTRL_TOP = 0;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ld_i,
    input  logic [TW-1:0] ld_val_i,
    input  logic          top_en_i,
    input  logic [TW-1:0] top_i,
    output logic [TW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          at_end;

    always_comb begin
        at_end = (cnt_q == {TW{1'b1}}) || (top_en_i && (cnt_q == top_i));
        wrap_o = at_end && !ld_i;
        if (ld_i) begin
            cnt_d = ld_val_i;
        end else if (at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R1: plain step when neither loaded nor wrapping
    a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + TW'(1)));

    // R7: a wrap always lands on zero
    a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_q == '0));

    // R8: in wrap-at-capture mode the capture value is the last count
    a_r8_top_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_en_i && (cnt_q == top_i) && !ld_i) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ld_i,
    input  logic [TW-1:0] ld_val_i,
    input  logic [TW-1:0] cnt_i,
    output logic [TW-1:0] cmp_o,
    output logic          match_o
);

    logic [TW-1:0] cmp_d, cmp_q;

    always_comb begin
        cmp_d   = ld_i ? ld_val_i : cmp_q;
        match_o = (cnt_i == cmp_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign cmp_o = cmp_q;

    // R3: a commit lands both bytes on one edge
    a_r3_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> (cmp_q == $past(ld_val_i)));

    // R2: without a commit the compare value does not move
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_i |=> $stable(cmp_q));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pin_i,
    input  logic          acomp_i,
    input  logic          sel_i,
    input  logic [TW-1:0] cnt_i,
    output logic [TW-1:0] cap_o,
    output logic          evt_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [TW-1:0]          cap;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    src;

    always_comb begin
        src        = sel_i ? acomp_i : pin_i;
        st_d       = st_q;
        st_d.sync  = {st_q.sync[SYNC_STAGES-2:0], src};
        st_d.prev  = st_q.sync[SYNC_STAGES-1];
        evt_o      = st_q.sync[SYNC_STAGES-1] && !st_q.prev;
        if (evt_o) begin
            st_d.cap = cnt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o = st_q.cap;

    // R6: the event samples the live counter
    a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> (st_q.cap == $past(cnt_i)));

    // R6: one event per rising edge
    a_r6_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> !evt_o);

    // R6: capture value held between events
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_o |=> $stable(st_q.cap));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import tmr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             gie_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] irq_o
);

    logic [N_SRC-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
        irq_o   = flags_q & mask_i & {N_SRC{gie_i}};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    // R10: a set always wins, even against a clear
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R10: a clear without a set empties the flag
    a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

    // R9: no request while globally disabled
    a_r9_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_i |-> (irq_o == '0));

endmodule

// File: rtl/tmr_busif.sv
module tmr_busif
    import tmr_pkg::*;
#(
    parameter  int BW = 8,
    localparam int TW = 2 * BW
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BW-1:0]            wdata_i,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [TW-1:0]            cnt_i,
    input  logic [N_CMP-1:0][TW-1:0] cmp_i,
    input  logic [TW-1:0]            cap_i,
    input  logic [N_SRC-1:0]         flags_i,
    output logic [BW-1:0]            rdata_o,
    output logic                     ld_cnt_o,
    output logic [N_CMP-1:0]         ld_cmp_o,
    output logic [TW-1:0]            ld_val_o,
    output logic [N_SRC-1:0]         clr_o,
    output logic [N_SRC-1:0]         mask_o,
    output logic                     top_en_o
);

    typedef struct packed {
        logic [BW-1:0]    temp;
        logic [N_SRC-1:0] mask;
        logic             top_en;
    } bus_st_t;

    bus_st_t   st_d, st_q;
    tmr_addr_e addr;

    assign addr = tmr_addr_e'(addr_i);

    always_comb begin
        st_d     = st_q;
        ld_cnt_o = 1'b0;
        ld_cmp_o = '0;
        clr_o    = '0;
        ld_val_o = {st_q.temp, wdata_i};
        rdata_o  = '0;

        if (wr_i) begin
            case (addr)
                A_CNT_HI, A_CMPA_HI, A_CMPB_HI, A_CAP_HI: st_d.temp = wdata_i;
                A_CNT_LO:  ld_cnt_o    = 1'b1;
                A_CMPA_LO: ld_cmp_o[0] = 1'b1;
                A_CMPB_LO: ld_cmp_o[1] = 1'b1;
                A_MASK:    st_d.mask   = wdata_i[FLAG_LSB +: N_SRC];
                A_FLAG:    clr_o       = wdata_i[FLAG_LSB +: N_SRC];
                A_CTRL:    st_d.top_en = wdata_i[CTRL_TOP];
                default: ;
            endcase
        end

        if (rd_i) begin
            case (addr)
                A_CNT_LO: begin
                    rdata_o   = cnt_i[BW-1:0];
                    st_d.temp = cnt_i[TW-1:BW];
                end
                A_CMPA_LO: begin
                    rdata_o   = cmp_i[0][BW-1:0];
                    st_d.temp = cmp_i[0][TW-1:BW];
                end
                A_CMPB_LO: begin
                    rdata_o   = cmp_i[1][BW-1:0];
                    st_d.temp = cmp_i[1][TW-1:BW];
                end
                A_CAP_LO: begin
                    rdata_o   = cap_i[BW-1:0];
                    st_d.temp = cap_i[TW-1:BW];
                end
                A_CNT_HI, A_CMPA_HI, A_CMPB_HI, A_CAP_HI: rdata_o = st_q.temp;
                A_MASK:   rdata_o[FLAG_LSB +: N_SRC] = st_q.mask;
                A_FLAG:   rdata_o[FLAG_LSB +: N_SRC] = flags_i;
                A_CTRL:   rdata_o[CTRL_TOP]          = st_q.top_en;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o   = st_q.mask;
    assign top_en_o = st_q.top_en;

    // R4: a low-byte capture read freezes the matching upper byte
    a_r4_cap_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && (addr_i == A_CAP_LO)) |=> (st_q.temp == $past(cap_i[TW-1:BW])));

    // R4: a low-byte counter read freezes the matching upper byte
    a_r4_cnt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && (addr_i == A_CNT_LO)) |=> (st_q.temp == $past(cnt_i[TW-1:BW])));

    // R2: an upper-byte write never commits
    a_r2_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i[0]) |-> (!ld_cnt_o && (ld_cmp_o == '0)));

endmodule

// File: rtl/bytebus_timer16.sv
module bytebus_timer16
    import tmr_pkg::*;
#(
    parameter  int BW          = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int TW          = 2 * BW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BW-1:0]     wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [BW-1:0]     rdata_o,
    input  logic              cap_pin_i,
    input  logic              acomp_i,
    input  logic              cap_sel_i,
    input  logic              gie_i,
    output logic              cmpa_match_o,
    output logic              cmpb_match_o,
    output logic              irq_cap_o,
    output logic              irq_cmpa_o,
    output logic              irq_cmpb_o,
    output logic              irq_ovf_o
);

    logic [TW-1:0]            cnt;
    logic                     wrap;
    logic [N_CMP-1:0][TW-1:0] cmp_val;
    logic [N_CMP-1:0]         match;
    logic [TW-1:0]            cap;
    logic                     cap_evt;
    logic                     ld_cnt;
    logic [N_CMP-1:0]         ld_cmp;
    logic [TW-1:0]            ld_val;
    logic [N_SRC-1:0]         clr;
    logic [N_SRC-1:0]         mask;
    logic                     top_en;
    logic [N_SRC-1:0]         flags;
    logic [N_SRC-1:0]         irq;
    logic [N_SRC-1:0]         set;

    tmr_busif #(.BW(BW)) u_busif (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .cnt_i    (cnt),
        .cmp_i    (cmp_val),
        .cap_i    (cap),
        .flags_i  (flags),
        .rdata_o  (rdata_o),
        .ld_cnt_o (ld_cnt),
        .ld_cmp_o (ld_cmp),
        .ld_val_o (ld_val),
        .clr_o    (clr),
        .mask_o   (mask),
        .top_en_o (top_en)
    );

    tmr_counter #(.TW(TW)) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (ld_cnt),
        .ld_val_i (ld_val),
        .top_en_i (top_en),
        .top_i    (cap),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        tmr_compare #(.TW(TW)) u_cmp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ld_i     (ld_cmp[i]),
            .ld_val_i (ld_val),
            .cnt_i    (cnt),
            .cmp_o    (cmp_val[i]),
            .match_o  (match[i])
        );
    end

    tmr_capture #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (cap_pin_i),
        .acomp_i (acomp_i),
        .sel_i   (cap_sel_i),
        .cnt_i   (cnt),
        .cap_o   (cap),
        .evt_o   (cap_evt)
    );

    always_comb begin
        set           = '0;
        set[SRC_OVF]  = wrap;
        set[SRC_CMPB] = match[1];
        set[SRC_CMPA] = match[0];
        set[SRC_CAP]  = cap_evt;
    end

    tmr_irq u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set),
        .clr_i   (clr),
        .mask_i  (mask),
        .gie_i   (gie_i),
        .flags_o (flags),
        .irq_o   (irq)
    );

    assign cmpa_match_o = match[0];
    assign cmpb_match_o = match[1];
    assign irq_cap_o    = irq[SRC_CAP];
    assign irq_cmpa_o   = irq[SRC_CMPA];
    assign irq_cmpb_o   = irq[SRC_CMPB];
    assign irq_ovf_o    = irq[SRC_OVF];

    // R5: a match is registered as a flag one edge later
    a_r5_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmpa_match_o |=> flags[SRC_CMPA]);

    // R7: a wrap is registered as the overflow flag
    a_r7_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> flags[SRC_OVF]);

endmodule

// File: tb/bytebus_timer16_bench.sv
`timescale 1ns/1ps
module bytebus_timer16_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       pin = 1'b0;
    logic       acomp = 1'b0;
    logic       sel = 1'b0;
    logic       gie = 1'b0;
    logic       m_a, m_b, i_cap, i_a, i_b, i_ovf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bytebus_timer16 u_bytebus_timer16 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .wr_i         (wr),
        .rd_i         (rd),
        .rdata_o      (rdata),
        .cap_pin_i    (pin),
        .acomp_i      (acomp),
        .cap_sel_i    (sel),
        .gie_i        (gie),
        .cmpa_match_o (m_a),
        .cmpb_match_o (m_b),
        .irq_cap_o    (i_cap),
        .irq_cmpa_o   (i_a),
        .irq_cmpb_o   (i_b),
        .irq_ovf_o    (i_ovf)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        bus_wr(lo | 4'h1, v[15:8]);
        bus_wr(lo, v[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq after reset", {i_cap, i_a, i_b, i_ovf}, 4'h0);
        bus_rd(4'h8, d); check("R1 mask reset", d, 8'h00);
        bus_rd(4'hA, d); check("R1 ctrl reset", d, 8'h00);
        bus_rd(4'h6, d); check("R1 capture low reset", d, 8'h00);
        bus_rd(4'h7, d); check("R1 capture high reset", d, 8'h00);
        bus_rd(4'h2, d); check("R1 compare A low reset", d, 8'h00);
    endtask

    task automatic t_count();
        logic [7:0] d;
        wr16(4'h0, 16'h0100);
        step(5);
        bus_rd(4'h0, d); check("R1 counter steps by one", d, 8'h05);
    endtask

    task automatic t_cnt_atomic();
        logic [7:0] d;
        wr16(4'h0, 16'h12FF);
        bus_rd(4'h0, d); check("R4 counter low byte", d, 8'hFF);
        bus_rd(4'h1, d); check("R4 counter high frozen", d, 8'h12);
    endtask

    task automatic t_hi_only();
        logic [7:0] d;
        wr16(4'h2, 16'h1111);
        bus_wr(4'h3, 8'hAB);
        bus_rd(4'h2, d); check("R2 compare A low unchanged", d, 8'h11);
        bus_rd(4'h3, d); check("R2 compare A high unchanged", d, 8'h11);
    endtask

    task automatic t_shared_temp();
        logic [7:0] d;
        bus_wr(4'h3, 8'h5A);
        bus_wr(4'h4, 8'hC3);
        bus_rd(4'h4, d); check("R3 compare B low", d, 8'hC3);
        bus_rd(4'h5, d); check("R3 compare B high via shared staging", d, 8'h5A);
        bus_rd(4'h2, d); check("R3 compare A untouched", d, 8'h11);
    endtask

    task automatic t_cmpa();
        wr16(4'h2, 16'h1003);
        bus_wr(4'h8, 8'h10);
        gie = 1'b1;
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'h1000);
        check("R5 no match at 0x1000", m_a, 1'b0);
        step(2);
        check("R5 no match at 0x1002", m_a, 1'b0);
        step(1);
        check("R5 match at 0x1003", m_a, 1'b1);
        check("R5 flag not yet set", i_a, 1'b0);
        step(1);
        check("R5 match ends", m_a, 1'b0);
        check("R5 R9 compare A request", i_a, 1'b1);
    endtask

    task automatic t_cmpb();
        wr16(4'h4, 16'h2002);
        bus_wr(4'h8, 8'h08);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'h2000);
        step(2);
        check("R5 compare B match", m_b, 1'b1);
        check("R5 compare A silent", m_a, 1'b0);
        step(1);
        check("R5 R9 compare B request", i_b, 1'b1);
    endtask

    task automatic t_cap_pin();
        logic [7:0] d;
        sel = 1'b0;
        bus_wr(4'h8, 8'h20);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'h20FC);
        pin = 1'b1;
        step(2);
        check("R6 capture flag not early", i_cap, 1'b0);
        step(1);
        check("R6 R9 capture request", i_cap, 1'b1);
        pin = 1'b0;
        bus_rd(4'h6, d); check("R6 captured low", d, 8'hFE);
        step(3);
        pin = 1'b1;
        step(3);
        bus_rd(4'h7, d); check("R4 high read keeps older sample", d, 8'h20);
        bus_rd(4'h6, d); check("R6 second capture low", d, 8'h05);
        bus_rd(4'h7, d); check("R6 second capture high", d, 8'h21);
        bus_wr(4'h9, 8'h00);
        check("R10 writing zero keeps flag", i_cap, 1'b1);
        bus_wr(4'h9, 8'h20);
        check("R10 writing one clears flag", i_cap, 1'b0);
        pin = 1'b0;
        step(3);
    endtask

    task automatic t_cap_comp();
        logic [7:0] d;
        sel = 1'b1;
        step(3);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'h3000);
        pin = 1'b1;
        step(4);
        check("R6 pin ignored when comparator selected", i_cap, 1'b0);
        bus_rd(4'h6, d); check("R6 capture unchanged", d, 8'h05);
        wr16(4'h0, 16'h3100);
        acomp = 1'b1;
        step(3);
        check("R6 comparator capture request", i_cap, 1'b1);
        bus_rd(4'h6, d); check("R6 comparator capture low", d, 8'h02);
        bus_rd(4'h7, d); check("R6 comparator capture high", d, 8'h31);
        pin = 1'b0;
        acomp = 1'b0;
        step(3);
        sel = 1'b0;
    endtask

    task automatic t_overflow();
        bus_wr(4'h8, 8'h04);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'hFFFE);
        check("R7 no overflow at 0xFFFE", i_ovf, 1'b0);
        step(1);
        check("R7 no overflow at 0xFFFF", i_ovf, 1'b0);
        step(1);
        check("R7 overflow after wrap", i_ovf, 1'b1);
        gie = 1'b0;
        #1 check("R9 global enable gates request", i_ovf, 1'b0);
        gie = 1'b1;
        #1 check("R9 request returns with global enable", i_ovf, 1'b1);
        step(1);
        bus_wr(4'h8, 8'h00);
        check("R9 mask bit gates request", i_ovf, 1'b0);
        bus_wr(4'h8, 8'h04);
        check("R9 unmasked again", i_ovf, 1'b1);
        bus_wr(4'h9, 8'h04);
        check("R10 overflow flag cleared", i_ovf, 1'b0);
    endtask

    task automatic t_top();
        logic [7:0] d;
        bus_wr(4'hA, 8'h01);
        bus_rd(4'hA, d); check("R8 control bit reads back", d, 8'h01);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'h3100);
        step(2);
        check("R8 no overflow at capture value", i_ovf, 1'b0);
        step(1);
        check("R8 overflow at capture value", i_ovf, 1'b1);
        bus_rd(4'h0, d); check("R8 counter wrapped to zero", d, 8'h00);
        bus_wr(4'hA, 8'h00);
        wr16(4'h0, 16'h3100);
        step(3);
        bus_rd(4'h0, d); check("R8 mode off passes capture value", d, 8'h03);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 irq in reset", {i_cap, i_a, i_b, i_ovf}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_cnt_atomic();
        t_hi_only();
        t_shared_temp();
        t_cmpa();
        t_cmpb();
        t_cap_pin();
        t_cap_comp();
        t_overflow();
        t_top();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule